// File: doc/BRIEF.md
# Memory Copy Engine Register and Command Unit

This block is the host-facing front end of a memory-to-memory copy engine. A host programs it through a plain 32-bit register bus. It holds the source address, the destination address, a 23-bit byte count and the interrupt enables. Writing the byte count while the unit is idle is the start trigger. The unit then offers exactly one copy command to a downstream data mover, waits for the mover's single completion report, and returns to idle. It issues no further command until the host starts one.

The unit logs each completion and each failure as sticky status flags. Failures come in three classes: internal, slave and decode. The host clears a flag by writing a one to its bit. A level interrupt stays high while a logged flag has its enable set. The host can run a transfer by polling the idle bit or by waiting for the interrupt.

The command output is a valid/ready stream. Once `cmd_valid` is high, it stays high and the payload stays frozen until the mover takes the command on a cycle with `cmd_ready` high. The completion report from the mover needs no ready. The unit always samples it, but it only accepts a report while a command has been taken and is still outstanding.

Top module: `cpy_engine_ctl`

## Requirements
- R1: After reset, the status register (offset 0x04) reads 0x0000_0002, which means only the idle bit (bit 1) is set. The other registers read 0, `cmd_valid` is 0 and `irq` is 0.
- R2: Register read data appears on `reg_rdata`, with `reg_rvalid` high, one cycle after a `reg_rd` strobe. The control register (0x00) keeps only bit 12 (completion interrupt enable) and bit 14 (error interrupt enable). Source (0x18) and destination (0x20) hold all 32 bits. The byte count (0x28) keeps bits 22:0. Unmapped offsets read 0.
- R3: A write to 0x28 while idle, with a nonzero count in bits 22:0, raises `cmd_valid` on the next cycle. The command carries the programmed source, destination and count, and status bit 1 reads 0 until the transfer ends.
- R4: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_src`, `cmd_dst` and `cmd_len` hold their values. After the accepting cycle, `cmd_valid` drops, and exactly one command is issued per start.
- R5: When a command is outstanding and `sts_valid` arrives with `sts_err` = 0, the unit sets status bit 12 (done) and returns to idle.
- R6: When a command is outstanding and `sts_valid` arrives with a nonzero `sts_err`, the unit sets status bit 14 (error). It also sets status bits 4, 5 and 6 for `sts_err` bits 0 (internal), 1 (slave) and 2 (decode), and it leaves bit 12 clear.
- R7: Writing 1 to status bit 12 clears done. Writing 1 to bit 14 clears the error flag and bits 4 to 6. Writing 0 leaves the flags unchanged.
- R8: Writes to the source, destination or byte-count registers while not idle are ignored. They change neither the stored values nor the command in flight, and they start no second command.
- R9: A byte-count write of zero while idle issues no command and leaves the unit idle. It sets status bits 14 and 4 (internal error).
- R10: `irq` is high while (status bit 12 and control bit 12) or (status bit 14 and control bit 14) is true. It follows enable changes on already logged flags.
- R11: `sts_valid` is ignored while the unit is idle or while the command has not yet been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| cmd_valid | output | 1 | Copy command offered |
| cmd_ready | input | 1 | Mover accepts the command |
| cmd_src | output | 32 | Command source address |
| cmd_dst | output | 32 | Command destination address |
| cmd_len | output | 23 | Command byte count |
| sts_valid | input | 1 | Mover completion report |
| sts_err | input | 3 | Error classes: bit0 internal, bit1 slave, bit2 decode |
| irq | output | 1 | Level interrupt |

## Verification
The bench holds `cmd_ready` low for several cycles. A unit that dropped the command or let its payload drift would lose or corrupt a copy. The bench also writes new addresses and counts during a transfer. A unit that did not gate these writes would retarget the copy in flight or launch a second one. Completion reports are sent early (before acceptance) and while idle. A unit that accepted them would finish a transfer that has not run, or log flags nobody caused. Zero-length starts, every error class, write-zero to status and enabling an interrupt after its flag is already logged each have their own test. These cases catch a unit that issues an empty command, mis-sorts error bits, clears on the wrong write, or latches the interrupt at the event instead of tracking the level.

// File: rtl/cpy_pkg.sv
package cpy_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_SRC  = 8'h18;
  localparam logic [7:0] OFS_DST  = 8'h20;
  localparam logic [7:0] OFS_LEN  = 8'h28;

  localparam int CTRL_IOC_BIT = 12;
  localparam int CTRL_ERR_BIT = 14;
  localparam int ST_IDLE_BIT  = 1;
  localparam int ST_KIND_LSB  = 4;
  localparam int ST_DONE_BIT  = 12;
  localparam int ST_ERR_BIT   = 14;

  localparam int NUM_KINDS = 3;
  localparam int KIND_INT  = 0;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cpy_regfile.sv
module cpy_regfile
  import cpy_pkg::*;
#(
  parameter int AW  = 8,
  parameter int ADW = 32,
  parameter int LW  = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  output logic [31:0]          reg_rdata,
  output logic                 reg_rvalid,
  input  logic                 idle,
  input  logic                 done_flag,
  input  logic                 err_flag,
  input  logic [NUM_KINDS-1:0] kind_flags,
  output logic [ADW-1:0]       src_q,
  output logic [ADW-1:0]       dst_q,
  output logic [LW-1:0]        len_q,
  output logic                 ioc_en,
  output logic                 err_en,
  output logic                 go,
  output logic [LW-1:0]        go_len,
  output logic                 clr_done,
  output logic                 clr_err
);
  logic hit_ctrl, hit_stat, hit_src, hit_dst, hit_len;
  logic [31:0] rd_mux, stat_word, ctrl_word;

  assign hit_ctrl = reg_addr == AW'(OFS_CTRL);
  assign hit_stat = reg_addr == AW'(OFS_STAT);
  assign hit_src  = reg_addr == AW'(OFS_SRC);
  assign hit_dst  = reg_addr == AW'(OFS_DST);
  assign hit_len  = reg_addr == AW'(OFS_LEN);

  assign go       = reg_wr && hit_len && idle;
  assign go_len   = reg_wdata[LW-1:0];
  assign clr_done = reg_wr && hit_stat && reg_wdata[ST_DONE_BIT];
  assign clr_err  = reg_wr && hit_stat && reg_wdata[ST_ERR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      ioc_en <= 1'b0;
      err_en <= 1'b0;
    end else if (reg_wr) begin
      if (hit_ctrl) begin
        ioc_en <= reg_wdata[CTRL_IOC_BIT];
        err_en <= reg_wdata[CTRL_ERR_BIT];
      end
      if (idle && hit_src) src_q <= reg_wdata[ADW-1:0];
      if (idle && hit_dst) dst_q <= reg_wdata[ADW-1:0];
      if (idle && hit_len) len_q <= reg_wdata[LW-1:0];
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[ST_IDLE_BIT] = idle;
    stat_word[ST_DONE_BIT] = done_flag;
    stat_word[ST_ERR_BIT]  = err_flag;
    stat_word[ST_KIND_LSB +: NUM_KINDS] = kind_flags;
    ctrl_word = '0;
    ctrl_word[CTRL_IOC_BIT] = ioc_en;
    ctrl_word[CTRL_ERR_BIT] = err_en;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux = ctrl_word;
    if (hit_stat) rd_mux = stat_word;
    if (hit_src)  rd_mux = 32'(src_q);
    if (hit_dst)  rd_mux = 32'(dst_q);
    if (hit_len)  rd_mux = 32'(len_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cpy_seq.sv
module cpy_seq
  import cpy_pkg::*;
#(
  parameter int LW = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [LW-1:0]        go_len,
  input  logic                 cmd_ready,
  input  logic                 sts_valid,
  input  logic [NUM_KINDS-1:0] sts_err,
  output logic                 busy,
  output logic                 cmd_valid,
  output logic                 evt_done,
  output logic [NUM_KINDS-1:0] evt_err,
  output logic                 evt_zero
);
  seq_state_e st_q, st_d;
  logic report;

  assign report   = (st_q == SQ_WAIT) && sts_valid;
  assign evt_done = report && (sts_err == '0);
  assign evt_err  = report ? sts_err : '0;
  assign evt_zero = (st_q == SQ_IDLE) && go && (go_len == '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:  if (go && go_len != '0) st_d = SQ_ISSUE;
      SQ_ISSUE: if (cmd_ready) st_d = SQ_WAIT;
      SQ_WAIT:  if (sts_valid) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign busy      = st_q != SQ_IDLE;
  assign cmd_valid = st_q == SQ_ISSUE;
endmodule

// File: rtl/cpy_status.sv
module cpy_status
  import cpy_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_done,
  input  logic [NUM_KINDS-1:0] evt_err,
  input  logic                 evt_zero,
  input  logic                 clr_done,
  input  logic                 clr_err,
  input  logic                 ioc_en,
  input  logic                 err_en,
  output logic                 done_flag,
  output logic                 err_flag,
  output logic [NUM_KINDS-1:0] kind_flags,
  output logic                 irq
);
  logic any_err;
  assign any_err = (|evt_err) || evt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      if (evt_done)      done_flag <= 1'b1;
      else if (clr_done) done_flag <= 1'b0;
      if (any_err)       err_flag  <= 1'b1;
      else if (clr_err)  err_flag  <= 1'b0;
    end
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    logic set_k;
    if (k == KIND_INT) begin : g_int
      assign set_k = evt_err[k] || evt_zero;
    end else begin : g_other
      assign set_k = evt_err[k];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)       kind_flags[k] <= 1'b0;
      else if (set_k)   kind_flags[k] <= 1'b1;
      else if (clr_err) kind_flags[k] <= 1'b0;
    end
  end

  assign irq = (done_flag && ioc_en) || (err_flag && err_en);
endmodule

// File: rtl/cpy_engine_ctl.sv
module cpy_engine_ctl
  import cpy_pkg::*;
#(
  parameter int AW  = 8,
  parameter int ADW = 32,
  parameter int LW  = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  output logic [31:0]          reg_rdata,
  output logic                 reg_rvalid,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [ADW-1:0]       cmd_src,
  output logic [ADW-1:0]       cmd_dst,
  output logic [LW-1:0]        cmd_len,
  input  logic                 sts_valid,
  input  logic [NUM_KINDS-1:0] sts_err,
  output logic                 irq
);
  logic busy, ioc_en, err_en, go, clr_done, clr_err;
  logic done_flag, err_flag, evt_done, evt_zero;
  logic [NUM_KINDS-1:0] kind_flags, evt_err;
  logic [LW-1:0] go_len;

  cpy_regfile #(.AW(AW), .ADW(ADW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .idle(!busy), .done_flag(done_flag),
    .err_flag(err_flag), .kind_flags(kind_flags), .src_q(cmd_src),
    .dst_q(cmd_dst), .len_q(cmd_len), .ioc_en(ioc_en), .err_en(err_en),
    .go(go), .go_len(go_len), .clr_done(clr_done), .clr_err(clr_err)
  );

  cpy_seq #(.LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .go_len(go_len),
    .cmd_ready(cmd_ready), .sts_valid(sts_valid), .sts_err(sts_err),
    .busy(busy), .cmd_valid(cmd_valid), .evt_done(evt_done),
    .evt_err(evt_err), .evt_zero(evt_zero)
  );

  cpy_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt_done(evt_done), .evt_err(evt_err),
    .evt_zero(evt_zero), .clr_done(clr_done), .clr_err(clr_err),
    .ioc_en(ioc_en), .err_en(err_en), .done_flag(done_flag),
    .err_flag(err_flag), .kind_flags(kind_flags), .irq(irq)
  );
endmodule

// File: rtl/cpy_engine_ctl_chk.sv
module cpy_engine_ctl_chk
  import cpy_pkg::*;
#(
  parameter int AW  = 8,
  parameter int ADW = 32,
  parameter int LW  = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [AW-1:0]        reg_addr,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic                 reg_rvalid,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [ADW-1:0]       cmd_src,
  input logic [ADW-1:0]       cmd_dst,
  input logic [LW-1:0]        cmd_len,
  input logic                 sts_valid,
  input logic [NUM_KINDS-1:0] sts_err,
  input logic                 irq,
  input logic                 busy,
  input logic                 ioc_en
);
  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  p_start_by_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(reg_wr && reg_addr == AW'(OFS_LEN)));

  p_hold_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src)
      && $stable(cmd_dst) && $stable(cmd_len));

  p_done_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_valid && sts_valid && sts_err == '0 && ioc_en && !reg_wr
      |=> irq && !busy);

  p_busy_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_src) && $stable(cmd_len));

  p_no_zero_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len != '0);

  p_stray_sts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && sts_valid && !cmd_ready |=> busy);
endmodule

bind cpy_engine_ctl cpy_engine_ctl_chk #(.AW(AW), .ADW(ADW), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_rvalid(reg_rvalid), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
  .cmd_len(cmd_len), .sts_valid(sts_valid), .sts_err(sts_err), .irq(irq),
  .busy(busy), .ioc_en(ioc_en)
);

// File: tb/cpy_engine_ctl_tb_top.sv
module cpy_engine_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] cmd_src, cmd_dst;
  logic [22:0] cmd_len;
  logic        sts_valid = 1'b0;
  logic [2:0]  sts_err = '0;
  logic        irq;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpy_engine_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
    .sts_valid(sts_valid), .sts_err(sts_err), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rvalid ? reg_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic accept();
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic report(input logic [2:0] e);
    sts_valid = 1'b1; sts_err = e;
    @(negedge clk);
    sts_valid = 1'b0; sts_err = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d); check("R1 status", d, 32'h2);
    rd(8'h00, d); check("R1 ctrl", d, 32'h0);
    rd(8'h18, d); check("R1 src", d, 32'h0);
    check("R1 cmd_valid", 32'(cmd_valid), 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R2 ctrl mask", d, 32'h0000_5000);
    wr(8'h18, 32'h1234_5678);
    rd(8'h18, d); check("R2 src", d, 32'h1234_5678);
    wr(8'h20, 32'hCAFE_0004);
    rd(8'h20, d); check("R2 dst", d, 32'hCAFE_0004);
    rd(8'h0C, d); check("R2 unmapped", d, 32'h0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_copy();
    logic [31:0] d;
    wr(8'h00, 32'h0000_1000);
    wr(8'h18, 32'h1000_0000);
    wr(8'h20, 32'h2000_0000);
    wr(8'h28, 32'hFF80_0040);
    check("R3 cmd_valid", 32'(cmd_valid), 1);
    check("R3 cmd_src", cmd_src, 32'h1000_0000);
    check("R3 cmd_dst", cmd_dst, 32'h2000_0000);
    check("R2 R3 cmd_len mask", 32'(cmd_len), 32'h40);
    rd(8'h04, d); check("R3 idle low", d, 32'h0);
    repeat (3) @(negedge clk);
    check("R4 held valid", 32'(cmd_valid), 1);
    check("R4 held src", cmd_src, 32'h1000_0000);
    accept();
    check("R4 drop after accept", 32'(cmd_valid), 0);
    check("R10 no irq yet", 32'(irq), 0);
    report(3'b000);
    check("R5 R10 irq", 32'(irq), 1);
    check("R4 single command", 32'(cmd_valid), 0);
    rd(8'h04, d); check("R5 status", d, 32'h0000_1002);
    wr(8'h04, 32'h0);
    rd(8'h04, d); check("R7 write zero", d, 32'h0000_1002);
    wr(8'h04, 32'h0000_1000);
    rd(8'h04, d); check("R7 clear done", d, 32'h2);
    check("R10 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_irq_level();
    wr(8'h00, 32'h0);
    wr(8'h28, 32'h10);
    accept();
    report(3'b000);
    check("R10 masked", 32'(irq), 0);
    wr(8'h00, 32'h0000_1000);
    check("R10 late enable", 32'(irq), 1);
    wr(8'h04, 32'h0000_1000);
    check("R10 after clear", 32'(irq), 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    wr(8'h18, 32'hAAAA_0000);
    wr(8'h28, 32'h100);
    wr(8'h18, 32'hBBBB_0000);
    wr(8'h20, 32'hCCCC_0000);
    wr(8'h28, 32'h5);
    check("R8 src kept", cmd_src, 32'hAAAA_0000);
    check("R8 dst kept", cmd_dst, 32'h2000_0000);
    check("R8 len kept", 32'(cmd_len), 32'h100);
    accept();
    wr(8'h28, 32'h7);
    check("R8 no second cmd", 32'(cmd_valid), 0);
    report(3'b000);
    check("R8 still no cmd", 32'(cmd_valid), 0);
    rd(8'h18, d); check("R8 src readback", d, 32'hAAAA_0000);
    rd(8'h28, d); check("R8 len readback", d, 32'h100);
    wr(8'h04, 32'h0000_5000);
  endtask

  task automatic t_errors();
    logic [31:0] d;
    wr(8'h00, 32'h0000_4000);
    wr(8'h28, 32'h20);
    accept();
    report(3'b010);
    rd(8'h04, d); check("R6 slave", d, 32'h0000_4022);
    check("R6 R10 err irq", 32'(irq), 1);
    wr(8'h28, 32'h20);
    accept();
    report(3'b101);
    rd(8'h04, d); check("R6 internal+decode sticky", d, 32'h0000_4072);
    wr(8'h04, 32'h0000_4000);
    rd(8'h04, d); check("R7 clear err", d, 32'h2);
    check("R7 irq low", 32'(irq), 0);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    wr(8'h28, 32'hFF80_0000);
    check("R9 no cmd", 32'(cmd_valid), 0);
    rd(8'h04, d); check("R9 status", d, 32'h0000_4012);
    check("R9 irq", 32'(irq), 1);
    wr(8'h04, 32'h0000_4000);
  endtask

  task automatic t_stray();
    logic [31:0] d;
    report(3'b000);
    rd(8'h04, d); check("R11 idle report ignored", d, 32'h2);
    wr(8'h28, 32'h8);
    report(3'b001);
    check("R11 early report ignored", 32'(cmd_valid), 1);
    rd(8'h04, d); check("R11 still busy", d, 32'h0);
    accept();
    report(3'b000);
    rd(8'h04, d); check("R11 real report", d, 32'h0000_1002);
    wr(8'h04, 32'h0000_1000);
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_copy();
    t_irq_level();
    t_busy_ignore();
    t_errors();
    t_zero();
    t_stray();
    finish_up();
  end
endmodule